// File: doc/BRIEF.md
# Edge-Cleared Watchdog Timer

This block watches a single toggle line that a processor drives from software. The line has no required polarity. What matters is that it changes level. Each change, low to high or high to low, restarts a timeout window measured in prescaled ticks. When a full window passes with no change, the block drives its active-low fault line low. That line is meant for a non-maskable interrupt input, or it can be looped back to a manual-reset input to force a system reset.

Two status inputs come from the neighbouring reset logic:

- A reset-busy flag holds the timer cleared. The window therefore starts only after reset has been released.
- A synchronized undervoltage flag forces the fault line low for as long as it is set. Whatever the timer state, the line comes back high on the next clock edge after the flag drops, unless the timer itself has expired.

The toggle line is asynchronous and passes through a two-stage synchronizer. The block then compares each synchronized sample with the one before it. A level held for a single sampling clock therefore yields two detected transitions.

Top module: `toggle_watchdog`

## Requirements
- R1: While `rst` is high, `wd_fault_n` is 1 and the timer and edge detector are cleared. The sync flops reset to 0.
- R2: `wd_fault_n` goes to 0 on the clock edge that accepts the TIMEOUT-th `tick_en` pulse counted since the timer was last cleared, provided no transition occurred in that time.
- R3: A rising or a falling change on `wd_in` clears the timer. The change acts on the third rising clock edge after it is set up at the input: two synchronizer flops, then one history flop.
- R4: A `wd_in` level that lasts exactly one clock period is seen as two transitions, and each one clears the timer.
- R5: Once flagged, the fault stays low through any further ticks until the timer is next cleared.
- R6: A transition that is recognized while the fault is flagged clears the timer and raises `wd_fault_n` on that same clock edge.
- R7: While `rst_busy` is 1, the timer is held at zero, no fault is flagged, and the window restarts from zero after `rst_busy` returns to 0.
- R8: On every clock edge that samples `uv_low` as 1, `wd_fault_n` is registered as 0, whatever the timer holds.
- R9: On the first clock edge that samples `uv_low` as 0 with no expired timer, `wd_fault_n` returns to 1 at once.
- R10: Clock edges with `tick_en` low do not advance the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaled timebase pulse, one clock wide |
| wd_in | input | 1 | Asynchronous processor toggle line |
| rst_busy | input | 1 | Reset generator holding its output active |
| uv_low | input | 1 | Synchronized undervoltage flag, 1 = supply low |
| wd_fault_n | output | 1 | Registered active-low watchdog fault |

## Verification
The bench aims at three kinds of corner case.

- **Timing of expiry and clearing.** It probes the exact clock edge on which the fault appears. A counter that is off by one would flag one tick early or one tick late. It also sends one-clock pulses on the toggle line: a detector that looked only at rising changes, or only at levels, would miss one clear of the pair.
- **Clearing after a fault.** It drives a transition after a fault has been flagged. A design that first cleared the flag and restarted the count one cycle later would show a single stale low cycle.
- **Status inputs.** It raises and drops the undervoltage flag while the timer sits in several states. A design that tied release to the timer, or to a fresh window, would hold the line low too long. It also checks that reset-busy keeps the window closed however long it lasts.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Number of flops in the input synchronizer; at least two.
  localparam int unsigned SYNC_DEPTH = 2;

  // One synchronized observation of the toggle line.
  typedef struct packed {
    logic level;   // current synchronized level
    logic change;  // level differs from the previous sample
  } wd_obs_t;
endpackage

// File: rtl/wdog_edge_sense.sv
module wdog_edge_sense
  import wdog_pkg::*;
#(
  parameter int unsigned DEPTH = SYNC_DEPTH
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    wd_in,
  output wd_obs_t obs
);
  logic [DEPTH-1:0] chain_q;
  logic             hist_q;

  // Synchronizer chain built by generate so the depth is a parameter.
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= wd_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  // History flop for comparing consecutive samples.
  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= chain_q[DEPTH-1];
  end

  assign obs.level  = chain_q[DEPTH-1];
  assign obs.change = chain_q[DEPTH-1] ^ hist_q;

  // A change means the history flop will take the new level next cycle.
  AST_CHANGE_SETTLES: assert property (@(posedge clk) disable iff (rst)
    obs.change |=> (hist_q == $past(obs.level)))
    else $error("change not absorbed"); // R3
endmodule

// File: rtl/wdog_window_timer.sv
module wdog_window_timer #(
  parameter int unsigned TIMEOUT = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic clear,
  output logic expired_q,
  output logic expired_nxt
);
  localparam int unsigned CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt     = cnt_q;
    expired_nxt = expired_q;
    if (clear) begin
      cnt_nxt     = '0;
      expired_nxt = 1'b0;
    end else if (tick_en && !expired_q) begin
      cnt_nxt = cnt_q + 1'b1;
      if (cnt_q == LAST) expired_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_nxt;
      expired_q <= expired_nxt;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(TIMEOUT)) else $error("count past window"); // R2
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt_q == '0 && !expired_q)) else $error("clear lost"); // R3
  AST_EXPIRED_STICKY: assert property (@(posedge clk) disable iff (rst)
    (expired_q && !clear) |=> expired_q) else $error("fault dropped"); // R5
  AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !clear) |=> $stable(cnt_q)) else $error("count moved"); // R10
endmodule

// File: rtl/wdog_fault_out.sv
module wdog_fault_out (
  input  logic clk,
  input  logic rst,
  input  logic uv_low,
  input  logic expired_nxt,
  output logic fault_n_q
);
  always_ff @(posedge clk) begin
    if (rst) fault_n_q <= 1'b1;
    else     fault_n_q <= ~(uv_low | expired_nxt);
  end

  AST_UV_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
    uv_low |=> !fault_n_q) else $error("undervoltage not forced"); // R8
endmodule

// File: rtl/toggle_watchdog.sv
module toggle_watchdog
  import wdog_pkg::*;
#(
  parameter int unsigned TIMEOUT = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  input  logic wd_in,
  input  logic rst_busy,
  input  logic uv_low,
  output logic wd_fault_n
);
  wd_obs_t obs;
  logic    expired_q, expired_nxt, clear;

  wdog_edge_sense #(.DEPTH(SYNC_DEPTH)) u_sense (
    .clk(clk), .rst(rst), .wd_in(wd_in), .obs(obs)
  );

  assign clear = obs.change | rst_busy;

  wdog_window_timer #(.TIMEOUT(TIMEOUT)) u_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .clear(clear),
    .expired_q(expired_q), .expired_nxt(expired_nxt)
  );

  wdog_fault_out u_out (
    .clk(clk), .rst(rst), .uv_low(uv_low),
    .expired_nxt(expired_nxt), .fault_n_q(wd_fault_n)
  );

  AST_BUSY_KEEPS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (rst_busy && !uv_low) |=> wd_fault_n) else $error("fault in reset"); // R7
  AST_FAULT_TRACKS_TIMER: assert property (@(posedge clk) disable iff (rst)
    (expired_q && !$past(uv_low)) |-> !wd_fault_n) else $error("fault lost"); // R2
endmodule

// File: tb/toggle_watchdog_tb.sv
module toggle_watchdog_tb;
  localparam int unsigned TO = 8;

  logic clk = 1'b0;
  logic rst, tick_en, wd_in, rst_busy, uv_low;
  logic wd_fault_n;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  int unsigned cyc = 0;
  bit          done = 1'b0;
  string       cur_req = "R1";

  always #10 clk = ~clk;

  toggle_watchdog #(.TIMEOUT(TO)) u_dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wd_in(wd_in),
    .rst_busy(rst_busy), .uv_low(uv_low), .wd_fault_n(wd_fault_n)
  );

  // Requirement-level reference: sync (R3), count (R2/R10), clear (R3/R7),
  // sticky fault (R5), undervoltage override (R8/R9).
  logic m_s1 = 0, m_s2 = 0, m_s3 = 0, m_exp = 0, m_fault_n = 1;
  int   m_cnt = 0;

  function automatic logic ref_fault_n(input logic uv, input logic ex);
    return !(uv || ex);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_exp = 0; m_fault_n = 1;
    end else begin
      if (rst_busy || (m_s2 ^ m_s3)) begin
        m_cnt = 0; m_exp = 0;
      end else if (tick_en && !m_exp) begin
        if (m_cnt == TO - 1) m_exp = 1;
        m_cnt++;
      end
      m_fault_n = ref_fault_n(uv_low, m_exp);
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = wd_in;
    end
  end

  task automatic chk(input string req, input logic exp_v);
    n_vec++;
    if (wd_fault_n !== exp_v) begin
      n_bad++;
      $display("FAIL %s: wd_fault_n=%b expected %b at cycle %0d",
               req, wd_fault_n, exp_v, cyc);
    end
  endtask

  // One cycle: check at negedge against the model, then drive new inputs.
  task automatic step(input logic t, input logic w, input logic b, input logic u);
    @(negedge clk);
    chk(cur_req, m_fault_n);
    tick_en = t; wd_in = w; rst_busy = b; uv_low = u;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, got %0d cycles expected below 150000", cyc);
      finish_run();
    end
  end

  initial begin
    logic w;
    void'($urandom(32'h5EED_0B1E));
    rst = 1; tick_en = 0; wd_in = 0; rst_busy = 0; uv_low = 0;
    repeat (3) @(negedge clk);
    chk("R1", 1'b1);                                 // R1: reset state
    @(negedge clk); rst = 0; tick_en = 1;

    // R2: exact expiry edge with no transitions
    cur_req = "R2";
    repeat (TO - 1) @(negedge clk);
    chk("R2", 1'b1);
    @(negedge clk);
    chk("R2", 1'b0);
    // R5: further ticks keep it low
    cur_req = "R5";
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0);
    @(negedge clk); chk("R5", 1'b0);

    // R6: transition after fault clears on the same edge it is seen
    tick_en = 1; wd_in = 1;                          // set at negedge k
    @(negedge clk); chk("R6", 1'b0);
    @(negedge clk); chk("R6", 1'b0);
    @(negedge clk); chk("R6", 1'b1);
    w = 1;

    // R3/R4: one-clock pulses keep the window open
    cur_req = "R4";
    for (int i = 0; i < 40; i++) begin
      step(1, (i % 6 == 2) ? ~w : w, 0, 0);
    end
    @(negedge clk); chk("R4", 1'b1);

    // R10: no ticks, never expires
    cur_req = "R10";
    for (int i = 0; i < 3 * TO; i++) step(0, w, 0, 0);
    @(negedge clk); chk("R10", 1'b1);

    // R7: long reset-busy hold
    cur_req = "R7";
    for (int i = 0; i < 3 * TO; i++) step(1, w, 1, 0);
    @(negedge clk); chk("R7", 1'b1);
    for (int i = 0; i < TO + 2; i++) step(1, w, 0, 0);

    // R8/R9: undervoltage while expired and while healthy
    cur_req = "R8";
    for (int i = 0; i < 4; i++) step(1, w, 0, 1);
    @(negedge clk); chk("R8", 1'b0);
    w = ~w;
    cur_req = "R9";
    for (int i = 0; i < 4; i++) step(1, w, 0, 1);
    step(0, w, 0, 0);                                // R9: release at once
    @(negedge clk); chk("R9", 1'b1);

    // Constrained random mix
    for (int i = 0; i < 6000; i++) begin
      logic t, b, u;
      int unsigned r = $urandom_range(0, 99);
      cur_req = (i % 2 == 0) ? "R3" : "R2";
      if (r < 12) w = ~w;
      t = ($urandom_range(0, 3) != 0);
      b = ($urandom_range(0, 99) < 3);
      u = ($urandom_range(0, 99) < 4);
      step(t, w, b, u);
    end
    @(negedge clk); chk("R3", m_fault_n);
    finish_run();
  end
endmodule